// File: doc/BRIEF.md
# Debug APB Access Permission Gate

This block sits between an APB slave port and a small bank of memory-mapped debug registers. For every APB transfer it decides whether the access is performed, quietly dropped, or answered with an error response. It bases that decision on four things. The first is the processor power state. The second is a privilege sideband driven by the system, which is needed because APB itself carries no privilege signal. The third is address bit 31, which marks transfers that come from the external debugger. The fourth is a software lock that the gate owns.

The gate holds the lock-access and lock-status registers. Every other index is handled by a plain register file behind the gate, apart from one read-only operating-system-lock status word that reports "not implemented". Each transfer finishes in the APB access phase with no wait states. A write strobe reaches the storage only when the permission check passes.

The lock is in its own reset domain. It is cleared only by the debug-logic reset, while the register file follows the APB/core reset. A parameter chooses whether unprivileged accesses get an error response or are ignored.

Top module: `dbg_apb_gate`

## Requirements
- R1: While `cpu_powered` is 0, every access phase returns `pslverr`=1 and `prdata`=0, and no register or lock state changes, whatever the other inputs are.
- R2: While powered, an access with `priv_access`=0 returns `pslverr`=1 and changes nothing when `UNPRIV_ERR`=1. When `UNPRIV_ERR`=0 it completes with `pslverr`=0, reads return 0 and writes are dropped.
- R3: A powered, privileged access with `paddr[31]`=1 (external debugger) succeeds at every index, whatever the lock state.
- R4: With `paddr[31]`=0 and the lock set, writes to every index except the lock-access index are dropped and still complete with `pslverr`=0. Writes to the lock-access index take effect.
- R5: With `paddr[31]`=0 and the lock clear, every powered, privileged access succeeds.
- R6: The lock-status word at index REG_WORDS-1 (word index `paddr[IDX_W+1:2]`) reads bit0=1 (lock present) and bit1=current lock state. All its other bits are 0, and writes to it have no effect.
- R7: The lock-access word at index REG_WORDS-2 clears the lock on a performed write of 0xC5ACCE55 and sets it on a performed write of any other value. It reads as 0.
- R8: The lock is set by `dbg_rst_n`=0 and is not affected by `presetn`. `presetn`=0 clears the storage words (indices 0 to REG_WORDS-4) to 0.
- R9: The OS-lock status word at index REG_WORDS-3 always reads 0 (not implemented), ignores writes and never blocks an access.
- R10: Reads are never blocked by the software lock. `pready` is always 1. Outside the access phase, `pslverr` and `prdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low APB/core reset, clears the storage words |
| dbg_rst_n | input | 1 | Active-low debug-logic reset, sets the software lock |
| cpu_powered | input | 1 | 1 while the processor is powered up |
| priv_access | input | 1 | System sideband: 1 for a privileged transfer |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | 32 | APB address; bit 31 marks external-debugger origin |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constantly 1 |
| pslverr | output | 1 | APB error response |

## Verification
The assertions assume that `psel`, `paddr`, `pwrite`, `pwdata`, `cpu_powered` and `priv_access` stay stable from the setup phase through the access phase. They also assume that `penable` is raised only one cycle after `psel`. The stimulus drives every transfer as a full setup-then-access pair and changes the sideband inputs only between transfers. It leaves `psel` low for a cycle between transfers, so no access phase ever sees a sideband change. Resets are applied between transfers and never in the middle of one.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
   localparam int          WORD_W     = 32;
   localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

   typedef enum logic [1:0] {
      ACC_PERFORM = 2'd0,
      ACC_DROP    = 2'd1,
      ACC_FAULT   = 2'd2
   } acc_verdict_e;
endpackage

// File: rtl/dbg_gate_decide.sv
module dbg_gate_decide
   import dbg_gate_pkg::*;
#(
   parameter int IDX_W      = 4,
   parameter int LAR_INDEX  = 14,
   parameter bit UNPRIV_ERR = 1'b1
) (
   input  logic             powered,
   input  logic             privileged,
   input  logic             dbg_origin,
   input  logic             is_write,
   input  logic             locked,
   input  logic [IDX_W-1:0] idx,
   output acc_verdict_e     verdict
);
   localparam logic [IDX_W-1:0] LAR_SEL = IDX_W'(LAR_INDEX);

   acc_verdict_e unpriv_verdict;

   generate
      if (UNPRIV_ERR) begin : g_unpriv_fault
         assign unpriv_verdict = ACC_FAULT;
      end else begin : g_unpriv_drop
         assign unpriv_verdict = ACC_DROP;
      end
   endgenerate

   always_comb begin
      if (!powered)
         verdict = ACC_FAULT;
      else if (!privileged)
         verdict = unpriv_verdict;
      else if (dbg_origin)
         verdict = ACC_PERFORM;
      else if (locked && is_write && (idx != LAR_SEL))
         verdict = ACC_DROP;
      else
         verdict = ACC_PERFORM;
   end
endmodule

// File: rtl/dbg_gate_lock.sv
module dbg_gate_lock
   import dbg_gate_pkg::*;
(
   input  logic              clk,
   input  logic              dbg_rst_n,
   input  logic              lar_we,
   input  logic [WORD_W-1:0] wdata,
   output logic              locked
);
   logic locked_q;

   always_ff @(posedge clk or negedge dbg_rst_n) begin
      if (!dbg_rst_n)
         locked_q <= 1'b1;
      else if (lar_we)
         locked_q <= (wdata != UNLOCK_KEY);
   end

   assign locked = locked_q;

   // R7: the key clears the lock, any other value sets it
   assert_key_unlocks_R7 : assert property (@(posedge clk) disable iff (!dbg_rst_n)
      (lar_we && (wdata == UNLOCK_KEY)) |=> !locked_q);
   assert_other_locks_R7 : assert property (@(posedge clk) disable iff (!dbg_rst_n)
      (lar_we && (wdata != UNLOCK_KEY)) |=> locked_q);
   // R8: the lock moves only through a lock-access write
   assert_lock_stable_R8 : assert property (@(posedge clk) disable iff (!dbg_rst_n)
      !$stable(locked_q) |-> $past(lar_we));
endmodule

// File: rtl/dbg_gate_regfile.sv
module dbg_gate_regfile #(
   parameter int WORDS  = 13,
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem_q [WORDS];

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem_q[w] <= '0;
            else if (we && (widx == IDX_W'(w)))
               mem_q[w] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int r = 0; r < WORDS; r++)
         if (ridx == IDX_W'(r))
            rdata = mem_q[r];
   end
endmodule

// File: rtl/dbg_apb_gate.sv
module dbg_apb_gate
   import dbg_gate_pkg::*;
#(
   parameter int REG_WORDS  = 16,
   parameter bit UNPRIV_ERR = 1'b1
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              dbg_rst_n,
   input  logic              cpu_powered,
   input  logic              priv_access,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [31:0]       paddr,
   input  logic [WORD_W-1:0] pwdata,
   output logic [WORD_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr
);
   localparam int IDX_W       = $clog2(REG_WORDS);
   localparam int STORE_WORDS = REG_WORDS - 3;
   localparam logic [IDX_W-1:0] OSL_SEL   = IDX_W'(REG_WORDS - 3);
   localparam logic [IDX_W-1:0] LAR_SEL   = IDX_W'(REG_WORDS - 2);
   localparam logic [IDX_W-1:0] LSR_SEL   = IDX_W'(REG_WORDS - 1);
   localparam logic [IDX_W-1:0] STORE_LIM = IDX_W'(STORE_WORDS);

   generate
      if (REG_WORDS < 4 || REG_WORDS > 1024 || (REG_WORDS & (REG_WORDS - 1)) != 0) begin : g_bad_words
         $error("REG_WORDS must be a power of two between 4 and 1024");
      end
      if (IDX_W + 2 > 31) begin : g_bad_span
         $error("register window overlaps the debugger origin bit");
      end
   endgenerate

   logic              access;
   logic [IDX_W-1:0]  idx;
   logic              locked;
   acc_verdict_e      verdict;
   logic              perform;
   logic              reg_we;
   logic              lar_we;
   logic [WORD_W-1:0] store_rdata;
   logic [WORD_W-1:0] word_rdata;
   logic              unused_addr;

   assign access      = psel & penable;
   assign idx         = paddr[IDX_W+1:2];
   assign unused_addr = ^{paddr[30:IDX_W+2], paddr[1:0]};

   dbg_gate_decide #(
      .IDX_W      (IDX_W),
      .LAR_INDEX  (REG_WORDS - 2),
      .UNPRIV_ERR (UNPRIV_ERR)
   ) decide_i (
      .powered    (cpu_powered),
      .privileged (priv_access),
      .dbg_origin (paddr[31]),
      .is_write   (pwrite),
      .locked     (locked),
      .idx        (idx),
      .verdict    (verdict)
   );

   assign perform = access && (verdict == ACC_PERFORM);
   assign reg_we  = perform && pwrite && (idx < STORE_LIM);
   assign lar_we  = perform && pwrite && (idx == LAR_SEL);

   dbg_gate_lock lock_i (
      .clk       (pclk),
      .dbg_rst_n (dbg_rst_n),
      .lar_we    (lar_we),
      .wdata     (pwdata),
      .locked    (locked)
   );

   dbg_gate_regfile #(
      .WORDS  (STORE_WORDS),
      .IDX_W  (IDX_W),
      .DATA_W (WORD_W)
   ) regs_i (
      .clk   (pclk),
      .rst_n (presetn),
      .we    (reg_we),
      .widx  (idx),
      .wdata (pwdata),
      .ridx  (idx),
      .rdata (store_rdata)
   );

   always_comb begin
      if (idx == LSR_SEL)
         word_rdata = {{(WORD_W-2){1'b0}}, locked, 1'b1};
      else if (idx == LAR_SEL || idx == OSL_SEL)
         word_rdata = '0;
      else
         word_rdata = store_rdata;
   end

   assign prdata  = (perform && !pwrite) ? word_rdata : '0;
   assign pslverr = access && (verdict == ACC_FAULT);
   assign pready  = 1'b1;

   // R1: powered-down transfers fault and write nothing
   assert_pwrdn_fault_R1 : assert property (@(posedge pclk) disable iff (!presetn)
      (access && !cpu_powered) |-> (pslverr && !reg_we && !lar_we));
   // R3: debugger-origin privileged transfers never fault
   assert_dbg_origin_ok_R3 : assert property (@(posedge pclk) disable iff (!presetn)
      (access && cpu_powered && priv_access && paddr[31]) |-> !pslverr);
   // R4: a storage write from software needs the lock clear
   assert_lock_blocks_R4 : assert property (@(posedge pclk) disable iff (!presetn)
      reg_we |-> (paddr[31] || !locked));
   // R6: the status word mirrors the lock
   assert_status_mirror_R6 : assert property (@(posedge pclk) disable iff (!presetn)
      (access && !pwrite && cpu_powered && priv_access && idx == LSR_SEL) |-> (prdata[1] == locked));
   // R10: the bus is quiet outside the access phase
   assert_idle_quiet_R10 : assert property (@(posedge pclk) disable iff (!presetn)
      !access |-> (!pslverr && prdata == '0));
endmodule

// File: tb/dbg_apb_gate_tb_top.sv
module dbg_apb_gate_tb_top;
   localparam int  NV  = 27;
   localparam logic [31:0] KEY = 32'hC5AC_CE55;

   typedef struct packed {
      logic        pwr;
      logic        priv;
      logic        a31;
      logic        wr;
      logic [3:0]  idx;
      logic [31:0] wd;
      logic        err;
      logic [31:0] rd;
      logic [3:0]  req;
   } vec_t;

   // fields: pwr priv a31 wr idx wdata exp_err exp_rdata requirement
   localparam vec_t VECS [NV] = '{
      '{1,1,0,0,15,32'h0,        0,32'h3,  6},  // R6 locked after reset
      '{1,1,0,1, 2,32'h11,       0,32'h0,  4},  // R4 dropped
      '{1,1,0,0, 2,32'h0,        0,32'h0,  4},  // R4
      '{1,1,1,1, 2,32'h22,       0,32'h0,  3},  // R3 debugger overrides
      '{1,1,0,0, 2,32'h0,        0,32'h22, 10}, // R10 read while locked
      '{1,1,0,1,14,32'h1234,     0,32'h0,  7},  // R7 wrong key
      '{1,1,0,0,15,32'h0,        0,32'h3,  7},  // R7
      '{1,1,0,0,14,32'h0,        0,32'h0,  7},  // R7 reads zero
      '{1,1,0,1,14,KEY,          0,32'h0,  4},  // R4 lock-access writable
      '{1,1,0,0,15,32'h0,        0,32'h1,  6},  // R6 unlocked
      '{1,1,0,1, 2,32'h33,       0,32'h0,  5},  // R5
      '{1,1,0,0, 2,32'h0,        0,32'h33, 5},  // R5
      '{0,1,0,0, 2,32'h0,        1,32'h0,  1},  // R1
      '{0,1,0,1, 2,32'h44,       1,32'h0,  1},  // R1
      '{0,1,1,1,14,32'h0,        1,32'h0,  1},  // R1 lock untouched
      '{1,1,0,0, 2,32'h0,        0,32'h33, 1},  // R1
      '{1,1,0,0,15,32'h0,        0,32'h1,  1},  // R1
      '{1,0,0,1, 2,32'h55,       1,32'h0,  2},  // R2
      '{1,0,0,0, 2,32'h0,        1,32'h0,  2},  // R2
      '{1,1,0,0, 2,32'h0,        0,32'h33, 2},  // R2
      '{1,1,0,0,13,32'h0,        0,32'h0,  9},  // R9
      '{1,1,1,1,13,32'hFF,       0,32'h0,  9},  // R9
      '{1,1,0,0,13,32'h0,        0,32'h0,  9},  // R9
      '{1,1,1,1,14,32'h0,        0,32'h0,  3},  // R3 debugger relocks
      '{1,1,0,0,15,32'h0,        0,32'h3,  6},  // R6
      '{1,1,0,1, 0,32'h66,       0,32'h0,  4},  // R4
      '{1,1,1,0, 0,32'h0,        0,32'h0,  4}   // R4
   };

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        dbg_rst_n = 1'b0;
   logic        cpu_powered = 1'b1;
   logic        priv_access = 1'b1;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [31:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata, prdata_b;
   logic        pready, pready_b, pslverr, pslverr_b;

   int tests = 0;
   int fails = 0;

   always #10 pclk = ~pclk;   // 50 MHz

   dbg_apb_gate #(.REG_WORDS(16), .UNPRIV_ERR(1'b1)) dut_i (
      .pclk(pclk), .presetn(presetn), .dbg_rst_n(dbg_rst_n),
      .cpu_powered(cpu_powered), .priv_access(priv_access),
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr));

   dbg_apb_gate #(.REG_WORDS(16), .UNPRIV_ERR(1'b0)) dut_ign_i (
      .pclk(pclk), .presetn(presetn), .dbg_rst_n(dbg_rst_n),
      .cpu_powered(cpu_powered), .priv_access(priv_access),
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .pwdata(pwdata), .prdata(prdata_b), .pready(pready_b), .pslverr(pslverr_b));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   logic        s_err, s_err_b, s_rdy;
   logic [31:0] s_rd, s_rd_b;

   task automatic apb(input logic pwr, input logic priv, input logic a31, input logic wr,
                      input logic [3:0] idx, input logic [31:0] wd);
      @(negedge pclk);
      cpu_powered = pwr; priv_access = priv;
      psel = 1'b1; penable = 1'b0; pwrite = wr;
      paddr = {a31, 25'd0, idx, 2'b00}; pwdata = wd;
      @(negedge pclk);
      penable = 1'b1;
      #5;
      s_err = pslverr; s_rd = prdata; s_rdy = pready;
      s_err_b = pslverr_b; s_rd_b = prdata_b;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      cpu_powered = 1'b1; priv_access = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge pclk);
      presetn = 1'b1; dbg_rst_n = 1'b1;
      @(negedge pclk);
      // R10: quiet bus after reset
      chk("R10 idle pslverr", {31'd0, pslverr}, 32'd0);
      chk("R10 idle prdata", prdata, 32'd0);
      chk("R10 pready", {31'd0, pready}, 32'd1);

      for (int v = 0; v < NV; v++) begin
         vec_t t;
         logic exp_err_b;
         string tg;
         t = VECS[v];
         tg = $sformatf("R%0d vec%0d", t.req, v);
         apb(t.pwr, t.priv, t.a31, t.wr, t.idx, t.wd);
         chk({tg, " pslverr"}, {31'd0, s_err}, {31'd0, t.err});
         chk({tg, " pready"}, {31'd0, s_rdy}, 32'd1);
         if (!t.wr) chk({tg, " prdata"}, s_rd, t.rd);
         // R2 ignore variant: unprivileged powered accesses complete cleanly
         exp_err_b = t.err && !(t.pwr && !t.priv);
         chk({tg, " R2 ign pslverr"}, {31'd0, s_err_b}, {31'd0, exp_err_b});
         if (!t.wr) chk({tg, " R2 ign prdata"}, s_rd_b, t.rd);
      end

      // R8: core reset keeps the lock, clears storage
      apb(1, 1, 0, 1, 14, KEY);
      apb(1, 1, 0, 1, 3, 32'hABCD);
      @(negedge pclk); presetn = 1'b0;
      @(negedge pclk); presetn = 1'b1;
      apb(1, 1, 0, 0, 15, 0);
      chk("R8 lock kept over presetn", s_rd, 32'h1);
      apb(1, 1, 0, 0, 3, 0);
      chk("R8 storage cleared", s_rd, 32'h0);
      @(negedge pclk); dbg_rst_n = 1'b0;
      @(negedge pclk); dbg_rst_n = 1'b1;
      apb(1, 1, 0, 0, 15, 0);
      chk("R8 debug reset sets lock", s_rd, 32'h3);
      // R6: status word ignores writes
      apb(1, 1, 1, 1, 15, 32'h0);
      apb(1, 1, 0, 0, 15, 0);
      chk("R6 status write ignored", s_rd, 32'h3);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule